// File: doc/BRIEF.md
# GPIO Interrupt Cause and Mask Unit

This block is the interrupt front end for a bank of 32 general-purpose input pins. Each pin is first brought into the clock domain through a two-stage synchronizer. It is then inverted or passed unchanged according to a per-pin polarity bit, and the result is the pin's adjusted input. The adjusted input serves directly as a level cause. A 0-to-1 step of the adjusted input is also caught in a sticky edge-pending register. Two independent enable registers, one for level and one for edge, gate these causes. The gated causes of each group of eight neighbouring pins are ORed together, and the four group results drive four registered request lines toward a main interrupt controller.

Software reaches the block through a simple word-wide register port. A write completes in one cycle. A read returns its data on the cycle after the read strobe. The polarity register lets software pick between high and low levels, or between rising and falling edges. To follow both edges of a pin, software flips that pin's polarity bit after each event. Pending edges are acknowledged by writing a word in which each 0 bit clears the matching pending bit.

Top module: `gpio_irq_front`

## Requirements
- R1: After a synchronous reset, the polarity, edge-enable, level-enable and edge-pending registers read as zero, and all four request lines are low.
- R2: The adjusted input of pin i is the pin's level after two synchronizer flops, XORed with polarity bit i. It reads at offset 0x110, and writes to that offset have no effect.
- R3: When level-enable bit i is 1 and the adjusted input of pin i is 1, the request line of that pin's group is high one cycle after the adjusted input is evaluated. It stays high while both conditions hold.
- R4: Edge-pending bit i is set when the adjusted input of pin i goes from 0 to 1. With polarity 0 this is a rising pin edge, and with polarity 1 it is a falling pin edge. The bit then stays set until software clears it. It reads at offset 0x114.
- R5: A write to offset 0x114 clears each edge-pending bit whose written bit is 0, and leaves each bit written as 1 unchanged. Writing all zeros clears every pending edge.
- R6: If a new edge and a clearing write hit the same edge-pending bit in the same cycle, the bit ends up set.
- R7: An edge-pending bit raises its group request only while its edge-enable bit is 1. With the enable at 0, the bit is still recorded and still readable.
- R8: Request line g is the OR of the gated causes of pins 8g to 8g+7, so the four lines cover pins 0-7, 8-15, 16-23 and 24-31.
- R9: Polarity at offset 0x10C, edge-enable at 0x118 and level-enable at 0x11C read back the last value written to them. A read of any other offset returns zero.
- R10: Read data is valid on the cycle after the read strobe and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous GPIO input levels |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| irq_o | output | 4 | Group request lines, one per eight pins |

## Verification
The block is driven with single pins walked through each group, which tells whether each group OR covers exactly its own eight pins. Mixed pin patterns under a partial polarity word show that the inversion acts per bit. Rising and falling steps with the edge enable off and then on separate the recording of an edge from its reporting. A clearing write is timed to land in the same cycle that an edge arrives, which exposes the priority between set and clear. Every cycle, both outputs are compared against a behavioural model of the synchronizer delay, the register updates and the read latency.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned OFS_W = 12;
  localparam logic [OFS_W-1:0] OFS_POLARITY = 12'h10C;
  localparam logic [OFS_W-1:0] OFS_ADJ_IN   = 12'h110;
  localparam logic [OFS_W-1:0] OFS_EDGE_PND = 12'h114;
  localparam logic [OFS_W-1:0] OFS_EDGE_EN  = 12'h118;
  localparam logic [OFS_W-1:0] OFS_LVL_EN   = 12'h11C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_POL, SEL_ADJ, SEL_PND, SEL_EEN, SEL_LEN
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] a);
    case (a)
      OFS_POLARITY: return SEL_POL;
      OFS_ADJ_IN:   return SEL_ADJ;
      OFS_EDGE_PND: return SEL_PND;
      OFS_EDGE_EN:  return SEL_EEN;
      OFS_LVL_EN:   return SEL_LEN;
      default:      return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] adj_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] keep_i,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] pend_q;
  logic [WIDTH-1:0] rise;
  logic [WIDTH-1:0] survive;

  assign rise    = adj_i & ~prev_q;
  assign survive = clr_en_i ? (pend_q & keep_i) : pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= adj_i;
      pend_q <= survive | rise;
    end
  end

  assign pend_o = pend_q;

  // R6: a fresh edge is never lost, even under a clearing write
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

  // R5: bits written as 0 drop unless an edge arrived with the write
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    clr_en_i |=> ((pend_q & ~$past(keep_i) & ~$past(rise)) == '0));

  // R4: pending bits are sticky without a clearing write
  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !clr_en_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/gpio_group_or.sv
module gpio_group_or #(
  parameter int unsigned WIDTH      = 32,
  parameter int unsigned GROUP_SIZE = 8,
  localparam int unsigned N_GROUPS  = WIDTH / GROUP_SIZE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [WIDTH-1:0]    cause_i,
  output logic [N_GROUPS-1:0] req_o
);
  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) req_o[g] <= 1'b0;
      else     req_o[g] <= |cause_i[g*GROUP_SIZE +: GROUP_SIZE];
    end
  end
endmodule

// File: rtl/gpio_irq_front.sv
module gpio_irq_front #(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned GROUP_SIZE  = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 12,
  localparam int unsigned N_GROUPS   = NUM_PINS / GROUP_SIZE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [NUM_PINS-1:0] reg_wdata,
  output logic [NUM_PINS-1:0] reg_rdata,
  output logic [N_GROUPS-1:0] irq_o
);
  import gpio_irq_pkg::*;

  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] adj_in;
  logic [NUM_PINS-1:0] pol_q, een_q, len_q;
  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] cause;
  reg_sel_e            sel;
  logic                pnd_clr;

  assign sel     = decode_ofs(OFS_W'(reg_addr));
  assign pnd_clr = reg_wr && (sel == SEL_PND);

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(pin_i), .sync_o(pin_sync));

  assign adj_in = pin_sync ^ pol_q;

  gpio_edge_latch #(.WIDTH(NUM_PINS)) u_edge (
    .clk(clk), .rst(rst), .adj_i(adj_in), .clr_en_i(pnd_clr),
    .keep_i(reg_wdata), .pend_o(pend));

  assign cause = (adj_in & len_q) | (pend & een_q);

  gpio_group_or #(.WIDTH(NUM_PINS), .GROUP_SIZE(GROUP_SIZE)) u_grp (
    .clk(clk), .rst(rst), .cause_i(cause), .req_o(irq_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= '0;
      een_q <= '0;
      len_q <= '0;
    end else if (reg_wr) begin
      case (sel)
        SEL_POL: pol_q <= reg_wdata;
        SEL_EEN: een_q <= reg_wdata;
        SEL_LEN: len_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !reg_rd) reg_rdata <= '0;
    else begin
      case (sel)
        SEL_POL: reg_rdata <= pol_q;
        SEL_ADJ: reg_rdata <= adj_in;
        SEL_PND: reg_rdata <= pend;
        SEL_EEN: reg_rdata <= een_q;
        SEL_LEN: reg_rdata <= len_q;
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R7: with both enables cleared, no request follows
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (len_q == '0 && een_q == '0) |=> (irq_o == '0));

  // R10: read data is zero unless a read was strobed
  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0));

  // R3: an enabled, active level raises its group request next cycle
  p_level_req_r3: assert property (@(posedge clk) disable iff (rst)
    ((adj_in & len_q) != '0) |=> (irq_o != '0));
endmodule

// File: tb/gpio_irq_front_tb_top.sv
module gpio_irq_front_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit chk_on = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_front dut_i (
    .clk(clk), .rst(rst), .pin_i(pins), .reg_wr(wr), .reg_rd(rd),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq));

  // behavioural reference, updated once per clock from pre-edge values
  bit [31:0] m_s1, m_s2, m_prev, m_pol, m_een, m_len, m_pnd, m_rdata;
  bit [3:0]  m_irq;

  always @(posedge clk) begin
    bit [31:0] adj, rise, cz, nrd;
    bit [3:0]  nirq;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_pol = 0; m_een = 0;
      m_len = 0; m_pnd = 0; m_rdata = 0; m_irq = 0;
    end else begin
      adj  = m_s2 ^ m_pol;
      rise = adj & ~m_prev;
      cz   = (adj & m_len) | (m_pnd & m_een);
      for (int g = 0; g < 4; g++) nirq[g] = ((cz >> (8*g)) & 32'hFF) != 0;
      nrd = 0;
      if (rd) begin
        if (addr == 12'h10C) nrd = m_pol;
        else if (addr == 12'h110) nrd = adj;
        else if (addr == 12'h114) nrd = m_pnd;
        else if (addr == 12'h118) nrd = m_een;
        else if (addr == 12'h11C) nrd = m_len;
      end
      if (wr && addr == 12'h114) m_pnd = m_pnd & wdata;
      m_pnd = m_pnd | rise;
      if (wr && addr == 12'h10C) m_pol = wdata;
      if (wr && addr == 12'h118) m_een = wdata;
      if (wr && addr == 12'h11C) m_len = wdata;
      m_prev = adj; m_s2 = m_s1; m_s1 = pins;
      m_irq = nirq; m_rdata = nrd;
    end
    chk_on <= 1'b1;
  end

  always @(negedge clk) begin
    if (chk_on) begin
      checks++;
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL %s irq_o actual=%h expected=%h t=%0t", cur_req, irq, m_irq, $time);
      end
      checks++;
      if (rdata !== m_rdata) begin
        fails++;
        $display("FAIL %s reg_rdata actual=%h expected=%h t=%0t", cur_req, rdata, m_rdata, $time);
      end
    end
  end

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk); pins = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    idle(3); rst = 1'b0;
    reg_read(12'h10C); reg_read(12'h110); reg_read(12'h114);
    reg_read(12'h118); reg_read(12'h11C);

    // R9: read-back and unmapped offset
    cur_req = "R9";
    reg_write(12'h118, 32'hA5A5_0F0F); reg_write(12'h11C, 32'h1234_5678);
    reg_read(12'h118); reg_read(12'h11C); reg_read(12'h100); reg_read(12'h120);
    reg_write(12'h118, 0); reg_write(12'h11C, 0);

    // R2: per-bit polarity and read-only adjusted input
    cur_req = "R2";
    set_pins(32'hF0F0_1234); reg_write(12'h10C, 32'h0000_FFFF);
    idle(3); reg_read(12'h110);
    reg_write(12'h110, 32'hDEAD_BEEF); reg_read(12'h110);
    reg_write(12'h10C, 0); set_pins(0); idle(3);
    reg_write(12'h114, 0);

    // R3 and R8: single pins walked through groups
    cur_req = "R3";
    reg_write(12'h11C, 32'hFFFF_FFFF);
    set_pins(32'h0000_0001); idle(4);
    cur_req = "R8";
    set_pins(32'h0000_0100); idle(4);
    set_pins(32'h0001_0000); idle(4);
    set_pins(32'h8000_0000); idle(4);
    set_pins(32'h0080_8000); idle(4);
    set_pins(0); idle(4);
    reg_write(12'h11C, 32'h0000_00FF); set_pins(32'h0000_FF00); idle(4);
    reg_write(12'h10C, 32'h0000_0003); idle(4);
    reg_write(12'h10C, 0); reg_write(12'h11C, 0); set_pins(0); idle(3);
    reg_write(12'h114, 0);

    // R4 and R7: rising edges recorded while disabled, then reported
    cur_req = "R7";
    set_pins(32'h0F00_0F01); idle(4); reg_read(12'h114);
    cur_req = "R4";
    reg_write(12'h118, 32'hFFFF_FFFF); idle(3);
    set_pins(32'h0F00_0F00); idle(4); reg_read(12'h114);
    reg_write(12'h10C, 32'h0000_0001); idle(3);
    reg_write(12'h114, 32'hFFFF_FFFE); idle(3); reg_read(12'h114);
    set_pins(32'h0F00_0F01); idle(4);
    set_pins(32'h0F00_0F00); idle(4); reg_read(12'h114);

    // R5: partial then full clear
    cur_req = "R5";
    reg_write(12'h114, 32'hFFFF_FF00); reg_read(12'h114);
    reg_write(12'h114, 32'h0000_0000); reg_read(12'h114); idle(2);

    // R6: clearing write lands with a new edge on pin 5
    cur_req = "R6";
    set_pins(32'h0F00_0F20);
    @(negedge clk);
    reg_write(12'h114, 32'h0000_0000);
    reg_read(12'h114); idle(2);

    // R7: disabling edge reports drops the request but keeps the bit
    cur_req = "R7";
    reg_write(12'h118, 0); idle(3); reg_read(12'h114);

    // R10: idle cycles with no read strobe
    cur_req = "R10";
    addr = 12'h114; idle(5);

    finish_run();
  end
endmodule